// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides one integer by another over many clock cycles, using one restoring shift-and-subtract step per cycle. It handles full-width and half-width operands, signed or unsigned. It returns either the quotient or the remainder, together with a four-bit condition code that classifies the result. An extended mode places the dividend operand in the upper half of a double-width dividend, which supports building wide quotients in software.

Signed operands are turned into magnitudes when the operation is accepted. The loop then divides the magnitudes, and the output stage puts the sign back. Every unrepresentable outcome gives a zero result with only the EQ condition bit set. This covers a zero divisor, a quotient of 2^WIDTH or more, a half-width quotient that spills into the upper half, and a signed quotient outside the two's-complement range. A caller pulses `start` while `busy` is low and waits for the one-cycle `valid` pulse. Results and conditions stay on the outputs until the next operation completes.

Top module: `iter_divider`

## Requirements
- R1: With `want_rem`=0 and `extended`=0, `result` is the quotient rounded toward zero, for unsigned operands and for signed two's-complement operands at full width.
- R2: With `want_rem`=1, `result` is the remainder. Its sign follows the dividend, and its magnitude is below the divisor magnitude.
- R3: With `extended`=1, the dividend is the dividend operand shifted left by the operand width (WIDTH bits at full width, WIDTH/2 bits at half width). The quotient of that value is returned.
- R4: A zero divisor gives `result`=0 and `cond`=4'b0010, for both quotient and remainder.
- R5: A quotient magnitude of 2^WIDTH or more gives `result`=0 and `cond`=4'b0010. This includes an extended divide whose dividend-operand magnitude is at least the divisor magnitude. A half-width quotient of 2^(WIDTH/2) or more gives the same.
- R6: A signed quotient is returned only if it lies in [-2^(W-1), 2^(W-1)-1], where W is the operand width. Otherwise the result is 0 with `cond`=4'b0010. A negative sign with zero magnitude is a plain zero and is not an overflow.
- R7: With `half_word`=1, only the low WIDTH/2 bits of each operand are used, and bit WIDTH/2-1 is the sign. A quotient is returned in the low half with the upper half zero, so `cond` never shows LT for it.
- R8: A half-width signed remainder that is negative is sign-extended, so its upper WIDTH/2 bits are all ones.
- R9: `cond` is computed from the full `result`: bit 3 LT (top bit set), bit 2 GT (top bit clear and nonzero), bit 1 EQ (all zero), bit 0 always 0. `cond_we` repeats the `rc_in` value captured at start.
- R10: If `start` is accepted at clock edge k, `valid` is high for exactly one cycle, following edge k+WIDTH+2.
- R11: `busy` goes high on the edge after an accepted start and stays high until the edge that raises `valid`. A `start` seen while `busy` is high is ignored and does not change the pending result.
- R12: After reset, `valid`, `busy`, `result`, `cond` and `cond_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| half_word | input | 1 | Use the low WIDTH/2 bits of each operand |
| signed_op | input | 1 | Treat operands as two's complement |
| want_rem | input | 1 | Return the remainder instead of the quotient |
| extended | input | 1 | Shift the dividend up by the operand width |
| rc_in | input | 1 | Request a condition-code write |
| busy | output | 1 | An operation is in progress |
| valid | output | 1 | One-cycle pulse: result and cond are new |
| result | output | WIDTH | Registered quotient or remainder |
| cond | output | 4 | Registered condition code {LT, GT, EQ, 0} |
| cond_we | output | 1 | Registered condition-write enable |

## Verification
The assertions check, on every cycle, the properties that hold for any operands. `valid` is a single-cycle pulse that follows the finish state. The captured controls do not move while busy. A zero divisor always raises the wide overflow flag, and that flag stays set once raised. A zero result always carries EQ alone, and a half-width quotient never has upper bits or LT. Arithmetic correctness, the signed range edges (most negative quotient, zero magnitude with negative sign), extended dividends, sign extension of half-width remainders, latency and the ignored start can only be shown by the bench. It runs directed scenarios against a reference model that divides double-width values in the bench.

// File: rtl/divq_pkg.sv
package divq_pkg;
  typedef enum logic [1:0] {
    DV_IDLE = 2'd0,
    DV_RUN  = 2'd1,
    DV_DONE = 2'd2
  } dv_state_e;

  // Controls captured when an operation is accepted
  typedef struct packed {
    logic half;
    logic is_mod;
    logic sgn;
    logic neg_quo;
    logic neg_rem;
    logic rc;
  } dv_ctl_t;
endpackage

// File: rtl/divq_mag.sv
module divq_mag #(
  parameter int N = 64
) (
  input  logic [N-1:0] x,
  input  logic         half,
  input  logic         sgn,
  output logic [N-1:0] mag,
  output logic         neg
);
  localparam int H = N / 2;

  logic [H-1:0] lo_abs;
  logic [N-1:0] full_abs;

  always_comb begin
    neg      = sgn & (half ? x[H-1] : x[N-1]);
    lo_abs   = neg ? (-x[H-1:0]) : x[H-1:0];
    full_abs = neg ? (-x) : x;
    mag      = half ? {{H{1'b0}}, lo_abs} : full_abs;
  end
endmodule

// File: rtl/divq_loop.sv
module divq_loop #(
  parameter int N = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           step,
  input  logic [2*N-1:0] dend_full,
  input  logic [N-1:0]   dsor,
  output logic [N-1:0]   quo,
  output logic [N-1:0]   rem,
  output logic           ovf_top,
  output logic           ovf_half
);
  localparam int H = N / 2;

  logic [N-1:0] rem_q, quo_q, dsor_q, diff;
  logic [N:0]   sh_q, trial;
  logic         first_q, ovf_top_q, ovf_half_q, ge;

  always_comb begin
    trial = {rem_q, sh_q[N]};
    ge    = trial >= {1'b0, dsor_q};
    diff  = trial[N-1:0] - dsor_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q      <= '0;
      quo_q      <= '0;
      dsor_q     <= '0;
      sh_q       <= '0;
      first_q    <= 1'b0;
      ovf_top_q  <= 1'b0;
      ovf_half_q <= 1'b0;
    end else if (load) begin
      rem_q      <= {1'b0, dend_full[2*N-1:N+1]};
      sh_q       <= dend_full[N:0];
      quo_q      <= '0;
      dsor_q     <= dsor;
      first_q    <= 1'b1;
      ovf_top_q  <= 1'b0;
      ovf_half_q <= 1'b0;
    end else if (step) begin
      rem_q   <= ge ? diff : trial[N-1:0];
      sh_q    <= {sh_q[N-1:0], 1'b0};
      quo_q   <= {quo_q[N-2:0], ge};
      first_q <= 1'b0;
      if (first_q && ge) ovf_top_q <= 1'b1;
      if (quo_q[H-1])    ovf_half_q <= 1'b1;
    end
  end

  assign quo      = quo_q;
  assign rem      = rem_q;
  assign ovf_top  = ovf_top_q;
  assign ovf_half = ovf_half_q;

  // R4
  zero_div_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (step && first_q && dsor_q == '0) |=> ovf_top_q);
  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_top_q && !load) |=> ovf_top_q);
endmodule

// File: rtl/divq_out.sv
module divq_out
  import divq_pkg::*;
#(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  dv_ctl_t      ctl,
  input  logic [N-1:0] quo,
  input  logic [N-1:0] rem,
  input  logic         ovf_top,
  input  logic         ovf_half,
  output logic [N-1:0] result_o,
  output logic [3:0]   cond_o,
  output logic         cond_we_o,
  output logic         valid_o
);
  localparam int H = N / 2;
  localparam logic [N-1:0] LIM_FULL = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] LIM_HALF = {{H{1'b0}}, 1'b1, {(H-1){1'b0}}};

  logic [N-1:0] lim, quo_signed, quo_res, rem_res, res;
  logic         range_bad, quo_bad, bad;
  logic [3:0]   cond_c;

  always_comb begin
    lim        = ctl.half ? LIM_HALF : LIM_FULL;
    range_bad  = ctl.sgn & (ctl.neg_quo ? (quo > lim) : (quo >= lim));
    quo_bad    = ovf_top | (ctl.half & ovf_half) | range_bad;
    quo_signed = ctl.neg_quo ? (-quo) : quo;
    quo_res    = ctl.half ? {{H{1'b0}}, quo_signed[H-1:0]} : quo_signed;
    rem_res    = ctl.neg_rem ? (-rem) : rem;
    bad        = ctl.is_mod ? ovf_top : quo_bad;
    res        = bad ? '0 : (ctl.is_mod ? rem_res : quo_res);
    cond_c     = {res[N-1], ~res[N-1] & (|res), ~(|res), 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_o  <= '0;
      cond_o    <= '0;
      cond_we_o <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= fire;
      if (fire) begin
        result_o  <= res;
        cond_o    <= cond_c;
        cond_we_o <= ctl.rc;
      end
    end
  end

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R4
  zero_eq_only_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && result_o == '0) |-> cond_o == 4'b0010);
  // R7
  half_quo_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && ctl.half && !ctl.is_mod) |-> (result_o[N-1:H] == '0 && !cond_o[3]));
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import divq_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             half_word,
  input  logic             signed_op,
  input  logic             want_rem,
  input  logic             extended,
  input  logic             rc_in,
  output logic             busy,
  output logic             valid,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       cond,
  output logic             cond_we
);
  localparam int HW = WIDTH / 2;
  localparam int CW = $clog2(WIDTH + 2);

  dv_state_e        state_q;
  logic [CW-1:0]    cnt_q;
  dv_ctl_t          ctl_q;
  logic             accept, step, fire;
  logic [WIDTH-1:0] a_mag, b_mag, quo, rem;
  logic             a_neg, b_neg, ovf_top, ovf_half;
  logic [2*WIDTH-1:0] dend_full;

  divq_mag #(.N(WIDTH)) u_mag_a (
    .x(dividend), .half(half_word), .sgn(signed_op), .mag(a_mag), .neg(a_neg)
  );
  divq_mag #(.N(WIDTH)) u_mag_b (
    .x(divisor), .half(half_word), .sgn(signed_op), .mag(b_mag), .neg(b_neg)
  );

  always_comb begin
    if (!extended)      dend_full = {{WIDTH{1'b0}}, a_mag};
    else if (half_word) dend_full = {{WIDTH{1'b0}}, a_mag[HW-1:0], {HW{1'b0}}};
    else                dend_full = {a_mag, {WIDTH{1'b0}}};
  end

  assign accept = start && (state_q == DV_IDLE);
  assign step   = (state_q == DV_RUN);
  assign fire   = (state_q == DV_DONE);
  assign busy   = (state_q != DV_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DV_IDLE;
      cnt_q   <= '0;
      ctl_q   <= '0;
    end else begin
      case (state_q)
        DV_IDLE: if (accept) begin
          state_q       <= DV_RUN;
          cnt_q         <= '0;
          ctl_q.half    <= half_word;
          ctl_q.is_mod  <= want_rem;
          ctl_q.sgn     <= signed_op;
          ctl_q.neg_quo <= a_neg ^ b_neg;
          ctl_q.neg_rem <= a_neg;
          ctl_q.rc      <= rc_in;
        end
        DV_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(WIDTH)) state_q <= DV_DONE;
        end
        default: state_q <= DV_IDLE;
      endcase
    end
  end

  divq_loop #(.N(WIDTH)) u_loop (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .dend_full(dend_full), .dsor(b_mag),
    .quo(quo), .rem(rem), .ovf_top(ovf_top), .ovf_half(ovf_half)
  );

  divq_out #(.N(WIDTH)) u_out (
    .clk(clk), .rst(rst), .fire(fire), .ctl(ctl_q),
    .quo(quo), .rem(rem), .ovf_top(ovf_top), .ovf_half(ovf_half),
    .result_o(result), .cond_o(cond), .cond_we_o(cond_we), .valid_o(valid)
  );

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctl_q));
  // R10
  valid_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(state_q) == DV_DONE);
  // R11
  run_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (accept) |=> busy);
endmodule

// File: tb/tb_iter_divider.sv
module tb_iter_divider;
  localparam int WIDTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [WIDTH-1:0] dividend = '0, divisor = '0;
  logic half_word = 0, signed_op = 0, want_rem = 0, extended = 0, rc_in = 0;
  logic busy, valid, cond_we;
  logic [WIDTH-1:0] result;
  logic [3:0] cond;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iter_divider #(.WIDTH(WIDTH)) dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .half_word(half_word), .signed_op(signed_op), .want_rem(want_rem),
    .extended(extended), .rc_in(rc_in), .busy(busy), .valid(valid),
    .result(result), .cond(cond), .cond_we(cond_we)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference model: {cond, result}
  function automatic logic [67:0] ref_div(input logic [63:0] a, input logic [63:0] b,
                                          input bit half, input bit sgn,
                                          input bit md, input bit ext);
    logic [127:0] A, D, q, r, lim;
    logic [63:0] am, bm, res;
    logic [31:0] t;
    bit sa, sb, nq, bad;
    sa = sgn && (half ? a[31] : a[63]);
    sb = sgn && (half ? b[31] : b[63]);
    if (half) begin
      t = a[31:0]; if (sa) t = -t; am = {32'h0, t};
      t = b[31:0]; if (sb) t = -t; bm = {32'h0, t};
    end else begin
      am = sa ? -a : a;
      bm = sb ? -b : b;
    end
    if (!ext) A = {64'h0, am};
    else if (half) A = {64'h0, am[31:0], 32'h0};
    else A = {am, 64'h0};
    D = {64'h0, bm};
    bad = (D == 0);
    q = bad ? '0 : A / D;
    r = bad ? '0 : A % D;
    if (md) begin
      bad = bad || (q[127:64] != 0);
      res = sa ? -r[63:0] : r[63:0];
    end else begin
      nq = sa ^ sb;
      if (half) begin
        bad = bad || (q[127:32] != 0);
        lim = 128'h1 << 31;
      end else begin
        bad = bad || (q[127:64] != 0);
        lim = 128'h1 << 63;
      end
      if (sgn) bad = bad || (nq ? (q > lim) : (q >= lim));
      res = nq ? -q[63:0] : q[63:0];
      if (half) res[63:32] = '0;
    end
    if (bad) res = '0;
    return {res[63], !res[63] && (res != 0), res == 0, 1'b0, res};
  endfunction

  task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                        input bit half, input bit sgn, input bit md, input bit ext,
                        input bit rc, output int lat);
    @(negedge clk);
    dividend = a; divisor = b; half_word = half; signed_op = sgn;
    want_rem = md; extended = ext; rc_in = rc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_case(input logic [63:0] a, input logic [63:0] b,
                         input bit half, input bit sgn, input bit md, input bit ext,
                         input string tag);
    logic [67:0] e;
    int lat;
    e = ref_div(a, b, half, sgn, md, ext);
    run_op(a, b, half, sgn, md, ext, 1'b1, lat);
    chk(valid === 1'b1, tag, "valid seen", {63'h0, valid}, 64'h1);
    chk(result === e[63:0], tag, "result", result, e[63:0]);
    chk(cond === e[67:64], "R9", "cond", {60'h0, cond}, {60'h0, e[67:64]});
  endtask

  task automatic t_reset;
    chk(valid === 0 && busy === 0 && cond_we === 0, "R12", "ctrl after reset",
        {61'h0, valid, busy, cond_we}, 64'h0);
    chk(result === '0, "R12", "result after reset", result, 64'h0);
    chk(cond === 4'h0, "R12", "cond after reset", {60'h0, cond}, 64'h0);
  endtask

  task automatic t_quotient64;
    do_case(64'd100, 64'd7, 0, 0, 0, 0, "R1");
    do_case(64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 0, 0, 0, 0, "R1");
    do_case(-64'sd100, 64'd7, 0, 1, 0, 0, "R1");
    do_case(64'd100, -64'sd7, 0, 1, 0, 0, "R1");
    do_case(-64'sd100, -64'sd7, 0, 1, 0, 0, "R1");
    do_case(64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0001_0001, 0, 0, 0, 0, "R1");
  endtask

  task automatic t_remainder;
    do_case(-64'sd100, 64'd7, 0, 1, 1, 0, "R2");
    do_case(64'd100, -64'sd7, 0, 1, 1, 0, "R2");
    do_case(64'hFFFF_FFFF_FFFF_FFF0, 64'd1000, 0, 0, 1, 0, "R2");
  endtask

  task automatic t_extended;
    do_case(64'd1, 64'd2, 0, 0, 0, 1, "R3");
    do_case(64'd1, 64'd4, 1, 0, 0, 1, "R3");
    do_case(64'd1, 64'd4, 0, 1, 0, 1, "R3");
    do_case(64'd5, 64'd5, 0, 0, 0, 1, "R5");
    do_case(64'd7, 64'd3, 1, 0, 0, 1, "R5");
  endtask

  task automatic t_zero_div;
    do_case(64'd55, 64'd0, 0, 0, 0, 0, "R4");
    chk(result === '0 && cond === 4'b0010, "R4", "div0 quotient zero/EQ",
        {cond, result[59:0]}, 64'h2000_0000_0000_0000);
    do_case(-64'sd55, 64'd0, 0, 1, 1, 0, "R4");
    do_case(64'd9, 64'h1234_5678_0000_0000, 1, 0, 0, 0, "R4");
  endtask

  task automatic t_signed_range;
    do_case(64'h8000_0000_0000_0000, -64'sd1, 0, 1, 0, 0, "R6");
    do_case(64'h8000_0000_0000_0000, 64'd1, 0, 1, 0, 0, "R6");
    do_case(64'd0, -64'sd5, 0, 1, 0, 0, "R6");
    do_case(64'd3, -64'sd5, 1, 1, 0, 0, "R6");
    do_case(64'h0000_0000_8000_0000, 64'hFFFF_FFFF, 1, 1, 0, 0, "R6");
    do_case(64'h0000_0000_8000_0000, 64'd1, 1, 1, 0, 0, "R6");
  endtask

  task automatic t_half;
    do_case(64'hFFFF_FFFF_FFFF_FFF6, 64'd3, 1, 1, 0, 0, "R7");
    chk(result[63:32] === 32'h0 && cond[3] === 1'b0, "R7", "upper half / LT",
        {result[63:32], 28'h0, cond}, {32'h0, 28'h0, 4'b0100});
    do_case(64'hDEAD_0000_0000_0064, 64'h1234_5678_0000_0007, 1, 0, 0, 0, "R7");
    do_case(64'h0000_0000_FFFF_FFFF, 64'd1, 1, 0, 0, 0, "R7");
  endtask

  task automatic t_half_rem;
    do_case(64'h0000_0000_FFFF_FFF6, 64'd3, 1, 1, 1, 0, "R8");
    chk(result === 64'hFFFF_FFFF_FFFF_FFFF, "R8", "sign-extended rem",
        result, 64'hFFFF_FFFF_FFFF_FFFF);
    do_case(64'h0000_0000_0000_000A, 64'hFFFF_FFFD, 1, 1, 1, 0, "R8");
  endtask

  task automatic t_cond_we;
    int lat;
    run_op(64'd20, 64'd4, 0, 0, 0, 0, 1'b0, lat);
    chk(cond_we === 1'b0, "R9", "cond_we with rc=0", {63'h0, cond_we}, 64'h0);
    run_op(64'd20, 64'd4, 0, 0, 0, 0, 1'b1, lat);
    chk(cond_we === 1'b1, "R9", "cond_we with rc=1", {63'h0, cond_we}, 64'h1);
    do_case(-64'sd20, 64'd4, 0, 1, 0, 0, "R9");
  endtask

  task automatic t_latency;
    int lat;
    logic [63:0] held;
    run_op(64'd1000, 64'd10, 0, 0, 0, 0, 1'b1, lat);
    chk(lat == WIDTH + 2, "R10", "latency", lat, WIDTH + 2);
    held = result;
    @(negedge clk);
    chk(valid === 1'b0, "R10", "valid one cycle", {63'h0, valid}, 64'h0);
    repeat (3) @(negedge clk);
    chk(result === held, "R10", "result held", result, held);
  endtask

  task automatic t_busy;
    logic [67:0] e;
    int lat;
    bit extra;
    e = ref_div(64'd500, 64'd7, 0, 0, 0, 0);
    @(negedge clk);
    dividend = 64'd500; divisor = 64'd7; half_word = 0; signed_op = 0;
    want_rem = 0; extended = 0; rc_in = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R11", "busy after start", {63'h0, busy}, 64'h1);
    repeat (5) @(negedge clk);
    dividend = 64'd9; divisor = 64'd2; want_rem = 1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(result === e[63:0], "R11", "start ignored while busy", result, e[63:0]);
    chk(busy === 1'b0, "R11", "busy low with valid", {63'h0, busy}, 64'h0);
    extra = 0;
    repeat (WIDTH + 6) begin
      @(negedge clk);
      if (valid) extra = 1;
    end
    chk(extra == 0, "R11", "no second result", {63'h0, extra}, 64'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_quotient64();
    t_remainder();
    t_extended();
    t_zero_div();
    t_signed_range();
    t_half();
    t_half_rem();
    t_cond_we();
    t_latency();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule